// File: doc/BRIEF.md
# Width-Reducing Dual-Clock FIFO

This block is a two-clock FIFO that stores 36-bit words written on one clock and hands them out as 18-bit half-words on a second, unrelated clock. Every stored word leaves as two reads. The order of the two halves is captured while reset is held. A high level on `msb_first_i` sends bits 35:18 out first. A low level sends bits 17:0 out first. The storage depth is a parameter (256 words by default, a power of two). The write and read pointers cross between the two clock domains as Gray code through two-flop synchronizers.

Two timing modes are chosen by `std_mode_i`, which is also captured during reset and must then stay fixed.

- **Standard mode:** `rd_status` means "not empty". A read strobe moves the next half-word onto `rd_data` at that read-clock edge.
- **Fall-through mode:** `rd_status` means "output ready". The next half-word is already on `rd_data` before any strobe, and a strobe moves on to the half-word after it.

In both modes `wr_status` reads high while a slot is free. It acts as a not-full flag in standard mode and as an input-ready flag in fall-through mode.

There are two programmable flags, both active low. `rd_aempty_n` is on the read clock and compares the stored-word count with a level. `wr_afull_n` is on the write clock and compares the free-slot count with a level. Both levels are taken from input ports while reset is held.

The read side is a small state machine with three states:

- **ST_CAPTURE:** held during reset. The configuration is captured here.
- **ST_FIRST:** the next half to take is the first half in the chosen order.
- **ST_SECOND:** the next half to take is the second half.

Its transitions are:

- ST_CAPTURE goes to ST_FIRST on the first edge after reset is released.
- ST_FIRST goes to ST_SECOND when a half is taken.
- ST_SECOND goes to ST_FIRST when a half is taken. This transition also advances the read pointer, which releases the slot.
- Any state goes back to ST_CAPTURE whenever reset is low.

Top module: `halfword_unpack_fifo`

## Requirements
- R1: A word is stored at a rising `wclk` edge only when `wr_sel_n` is low, `wr_en` is high and `wr_status` is high. Any other write attempt stores nothing, including an attempt made while the FIFO is full.
- R2: A read strobe at a rising `rclk` edge requires `rd_sel_n` low and `rd_en` high. Without both, `rd_data` and the stored content are left unchanged.
- R3: `msb_first_i` is sampled while `rst_n` is low. With 1, bits 35:18 of a word are delivered before bits 17:0. With 0, bits 17:0 come first. Changing the pin after reset has no effect.
- R4: Standard mode (`std_mode_i` high during reset, then static) works as follows.
  - `rd_status` is high exactly when at least one word, or a word with one half still unread, is stored.
  - A strobe while `rd_status` is high places the next half-word on `rd_data` after that `rclk` edge.
  - A strobe while `rd_status` is low leaves `rd_data` unchanged.
- R5: Fall-through mode (`std_mode_i` low during reset, then static) works as follows.
  - A high `rd_status` means `rd_data` already holds the next half-word, with no strobe needed.
  - That half-word stays put until a strobe.
  - A strobe advances `rd_data` to the following half-word, or drops `rd_status` when none is stored.
- R6: `wr_status` is high while the write side sees at least one free slot, and low once DEPTH words are stored. A slot is returned only after both of its halves have been read, so reading one half of a full FIFO keeps `wr_status` low.
- R7: `rd_aempty_n` is low when the number of stored words is less than or equal to `ae_level_i`, as captured during reset. A word with one half still unread counts as stored.
- R8: `wr_afull_n` is low when the number of free slots is less than or equal to `af_level_i`, as captured during reset.
- R9: A synchronous reset, held for several cycles of both clocks, empties the FIFO. It leaves the outputs as follows:
  - `rd_status` low;
  - `wr_status` high;
  - `rd_aempty_n` low;
  - `wr_afull_n` high when the level is below DEPTH;
  - `rd_data` zero.
- R10: Pointers cross clock domains as Gray code through two flops, changing at most one bit per source edge. Status therefore turns "available" at least two destination edges after the causing transfer and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock, independent of `wclk` |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| msb_first_i | input | 1 | Half order, sampled during reset (1 = upper half first) |
| std_mode_i | input | 1 | Timing mode, sampled during reset (1 = standard, 0 = fall-through) |
| ae_level_i | input | $clog2(DEPTH)+1 | Almost-empty level, sampled during reset |
| af_level_i | input | $clog2(DEPTH)+1 | Almost-full level, sampled during reset |
| wr_sel_n | input | 1 | Write-port select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | WORD_W | Word to store |
| wr_status | output | 1 | High while a slot is free (not-full / input-ready) |
| wr_afull_n | output | 1 | Almost-full flag, active low, on `wclk` |
| rd_sel_n | input | 1 | Read-port select, active low |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | WORD_W/2 | Half-word output |
| rd_status | output | 1 | Not-empty (standard) or output-ready (fall-through) |
| rd_aempty_n | output | 1 | Almost-empty flag, active low, on `rclk` |

## Verification
The hardest case to reach is a completely full store with exactly one half of the oldest word read. Only in that case does the rule "a slot is freed only after its second half" decide whether `wr_status` rises. The bench writes a burst of exactly DEPTH words and checks the almost-full threshold on the way up. It then offers one extra word, which must be dropped. Next it reads a single half-word and waits for the pointer to cross back, confirming that `wr_status` stays low. After the second half it confirms that `wr_status` rises. It then drains all 2·DEPTH half-words in order to show that the dropped word never entered storage.

// File: rtl/huf_pkg.sv
package huf_pkg;

    // Read-side unpacking states
    typedef enum logic [1:0] {
        ST_CAPTURE = 2'd0,
        ST_FIRST   = 2'd1,
        ST_SECOND  = 2'd2
    } unpack_state_t;

    // Half order captured at reset
    typedef enum logic {
        ORDER_LOW_FIRST  = 1'b0,
        ORDER_HIGH_FIRST = 1'b1
    } half_order_t;

    // Timing mode captured at reset
    typedef enum logic {
        MODE_FALLTHRU = 1'b0,
        MODE_STANDARD = 1'b1
    } timing_mode_t;

endpackage

// File: rtl/huf_sync.sv
module huf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/huf_gray2bin.sv
module huf_gray2bin #(
    parameter int W = 9
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end

endmodule

// File: rtl/huf_wr_ctrl.sv
module huf_wr_ctrl #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [AW:0]   rgray_s,
    input  logic [AW:0]   af_level,
    output logic          wr_ready,
    output logic          wr_afull_n,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray
);

    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [AW:0] wbin;
    logic [AW:0] wbin_nxt;
    logic [AW:0] rbin;
    logic [AW:0] used;
    logic [AW:0] free_cnt;
    logic [AW:0] af_cfg;

    huf_gray2bin #(.W(AW+1)) u_r2b (
        .gray (rgray_s),
        .bin  (rbin)
    );

    always_comb begin
        used       = wbin - rbin;
        free_cnt   = FULL_CNT - used;
        wr_ready   = (used != FULL_CNT);
        wr_afull_n = !(free_cnt <= af_cfg);
        push       = push_req && wr_ready;
        wbin_nxt   = wbin + (AW+1)'(push);
    end

    assign waddr = wbin[AW-1:0];

    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            af_cfg <= af_level;
        end else begin
            wbin   <= wbin_nxt;
            wgray  <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // R1
    full_block_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (push_req && !wr_ready) |=> (wbin == $past(wbin)));

    // R6
    used_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        used <= FULL_CNT);

    // R10
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: rtl/huf_rd_ctrl.sv
module huf_rd_ctrl
    import huf_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int WORD_W = 36,
    parameter int AW     = $clog2(DEPTH),
    parameter int HALF_W = WORD_W / 2
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              pop_req,
    input  logic              order_in,
    input  logic              mode_in,
    input  logic [AW:0]       ae_level,
    input  logic [AW:0]       wgray_s,
    input  logic [WORD_W-1:0] word_in,
    output logic [AW-1:0]     raddr,
    output logic [AW:0]       rgray,
    output logic [HALF_W-1:0] rd_data,
    output logic              rd_status,
    output logic              rd_aempty_n
);

    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    unpack_state_t     state;
    unpack_state_t     state_nxt;
    half_order_t       order_cfg;
    timing_mode_t      mode_cfg;
    logic [AW:0]       rbin;
    logic [AW:0]       rbin_nxt;
    logic [AW:0]       wbin;
    logic [AW:0]       stored;
    logic [AW:0]       ae_cfg;
    logic              avail;
    logic              take;
    logic              high_sel;
    logic              out_valid;
    logic [HALF_W-1:0] half_word;

    huf_gray2bin #(.W(AW+1)) u_w2b (
        .gray (wgray_s),
        .bin  (wbin)
    );

    // Half selection and take decision
    always_comb begin : datapath
        stored = wbin - rbin;
        avail  = (stored != '0) && (state != ST_CAPTURE);
        if (mode_cfg == MODE_STANDARD) begin
            take = pop_req && avail;
        end else begin
            take = avail && (!out_valid || pop_req);
        end
        high_sel  = ((state == ST_FIRST) == (order_cfg == ORDER_HIGH_FIRST));
        half_word = high_sel ? word_in[WORD_W-1:HALF_W] : word_in[HALF_W-1:0];
        rbin_nxt  = rbin + (AW+1)'(take && (state == ST_SECOND));
    end

    // State register
    always_ff @(posedge rclk) begin : state_reg
        if (!rst_n) begin
            state <= ST_CAPTURE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin : next_state
        state_nxt = state;
        unique case (state)
            ST_CAPTURE: state_nxt = ST_FIRST;
            ST_FIRST:   if (take) state_nxt = ST_SECOND;
            ST_SECOND:  if (take) state_nxt = ST_FIRST;
            default:    state_nxt = ST_CAPTURE;
        endcase
    end

    // Status outputs
    always_comb begin : outputs
        rd_status   = (mode_cfg == MODE_STANDARD) ? avail : out_valid;
        rd_aempty_n = !(stored <= ae_cfg);
        raddr       = rbin[AW-1:0];
    end

    // Pointer, output half and configuration capture
    always_ff @(posedge rclk) begin : data_reg
        if (!rst_n) begin
            rbin      <= '0;
            rgray     <= '0;
            rd_data   <= '0;
            out_valid <= 1'b0;
            order_cfg <= half_order_t'(order_in);
            mode_cfg  <= timing_mode_t'(mode_in);
            ae_cfg    <= ae_level;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
            if (take) begin
                rd_data <= half_word;
            end
            if (take) begin
                out_valid <= 1'b1;
            end else if (pop_req) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R4
    empty_read_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode_cfg == MODE_STANDARD && pop_req && !avail) |=> $stable(rd_data));

    // R5
    fallthru_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode_cfg == MODE_FALLTHRU && out_valid && !pop_req) |=> (out_valid && $stable(rd_data)));

    // R6
    stored_bound_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        stored <= FULL_CNT);

    // R10
    rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: rtl/halfword_unpack_fifo.sv
module halfword_unpack_fifo #(
    parameter int DEPTH  = 256,
    parameter int WORD_W = 36
) (
    input  logic                    wclk,
    input  logic                    rclk,
    input  logic                    rst_n,
    input  logic                    msb_first_i,
    input  logic                    std_mode_i,
    input  logic [$clog2(DEPTH):0]  ae_level_i,
    input  logic [$clog2(DEPTH):0]  af_level_i,
    input  logic                    wr_sel_n,
    input  logic                    wr_en,
    input  logic [WORD_W-1:0]       wr_data,
    output logic                    wr_status,
    output logic                    wr_afull_n,
    input  logic                    rd_sel_n,
    input  logic                    rd_en,
    output logic [WORD_W/2-1:0]     rd_data,
    output logic                    rd_status,
    output logic                    rd_aempty_n
);

    localparam int AW     = $clog2(DEPTH);
    localparam int HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] store_q [DEPTH];
    logic              push;
    logic              push_req;
    logic              pop_req;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic [AW:0]       wgray;
    logic [AW:0]       rgray;
    logic [AW:0]       wgray_r;
    logic [AW:0]       rgray_w;

    assign push_req = !wr_sel_n && wr_en;
    assign pop_req  = !rd_sel_n && rd_en;

    always_ff @(posedge wclk) begin
        if (push) begin
            store_q[waddr] <= wr_data;
        end
    end

    huf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .wclk       (wclk),
        .rst_n      (rst_n),
        .push_req   (push_req),
        .rgray_s    (rgray_w),
        .af_level   (af_level_i),
        .wr_ready   (wr_status),
        .wr_afull_n (wr_afull_n),
        .push       (push),
        .waddr      (waddr),
        .wgray      (wgray)
    );

    huf_sync #(.W(AW+1)) u_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_r)
    );

    huf_sync #(.W(AW+1)) u_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_w)
    );

    huf_rd_ctrl #(.DEPTH(DEPTH), .WORD_W(WORD_W), .HALF_W(HALF_W)) u_rd (
        .rclk        (rclk),
        .rst_n       (rst_n),
        .pop_req     (pop_req),
        .order_in    (msb_first_i),
        .mode_in     (std_mode_i),
        .ae_level    (ae_level_i),
        .wgray_s     (wgray_r),
        .word_in     (store_q[raddr]),
        .raddr       (raddr),
        .rgray       (rgray),
        .rd_data     (rd_data),
        .rd_status   (rd_status),
        .rd_aempty_n (rd_aempty_n)
    );

endmodule

// File: tb/tb_halfword_unpack_fifo.sv
module tb_halfword_unpack_fifo;

    localparam int WCLK_PERIOD = 12;
    localparam int RCLK_PERIOD = 16;
    localparam int DEPTH = 256;
    localparam int WW    = 36;
    localparam int HW    = 18;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msb_first = 1'b1;
    logic          std_mode = 1'b1;
    logic [LW-1:0] ae_level = LW'(3);
    logic [LW-1:0] af_level = LW'(4);
    logic          wr_sel_n = 1'b1;
    logic          wr_en = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic          wr_status;
    logic          wr_afull_n;
    logic          rd_sel_n = 1'b1;
    logic          rd_en = 1'b0;
    logic [HW-1:0] rd_data;
    logic          rd_status;
    logic          rd_aempty_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [WW-1:0] W1 = 36'h912345678;
    localparam logic [WW-1:0] W2 = 36'h3C3C5A5A1;
    localparam logic [WW-1:0] W3 = 36'h7E81F00F5;

    // write edges fall on even times, read edges on odd times
    always #(WCLK_PERIOD/2) wclk = ~wclk;
    initial begin
        #1;
        forever #(RCLK_PERIOD/2) rclk = ~rclk;
    end

    halfword_unpack_fifo #(.DEPTH(DEPTH), .WORD_W(WW)) dut (
        .wclk        (wclk),
        .rclk        (rclk),
        .rst_n       (rst_n),
        .msb_first_i (msb_first),
        .std_mode_i  (std_mode),
        .ae_level_i  (ae_level),
        .af_level_i  (af_level),
        .wr_sel_n    (wr_sel_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .wr_status   (wr_status),
        .wr_afull_n  (wr_afull_n),
        .rd_sel_n    (rd_sel_n),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .rd_status   (rd_status),
        .rd_aempty_n (rd_aempty_n)
    );

    function automatic logic [HW-1:0] hi(input logic [WW-1:0] w);
        return w[WW-1:HW];
    endfunction

    function automatic logic [HW-1:0] lo(input logic [WW-1:0] w);
        return w[HW-1:0];
    endfunction

    function automatic logic [WW-1:0] fill_word(input int i);
        return {4'hC, 16'(i), ~16'(i)};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic msb, input logic std);
        @(negedge wclk);
        rst_n = 1'b0;
        msb_first = msb;
        std_mode = std;
        wr_sel_n = 1'b1;
        wr_en = 1'b0;
        rd_sel_n = 1'b1;
        rd_en = 1'b0;
        repeat (5) @(negedge rclk);
        @(negedge wclk);
        rst_n = 1'b1;
        repeat (3) @(negedge rclk);
    endtask

    task automatic push_word(input logic [WW-1:0] w, input logic sel_n);
        @(negedge wclk);
        wr_sel_n = sel_n;
        wr_en = 1'b1;
        wr_data = w;
        @(negedge wclk);
        wr_sel_n = 1'b1;
        wr_en = 1'b0;
    endtask

    task automatic push_burst(input int base, input int n);
        @(negedge wclk);
        for (int i = 0; i < n; i++) begin
            wr_sel_n = 1'b0;
            wr_en = 1'b1;
            wr_data = fill_word(base + i);
            @(negedge wclk);
        end
        wr_sel_n = 1'b1;
        wr_en = 1'b0;
    endtask

    task automatic strobe_rd(input logic sel_n, input logic en);
        @(negedge rclk);
        rd_sel_n = sel_n;
        rd_en = en;
        @(negedge rclk);
        rd_sel_n = 1'b1;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic test_reset_state();
        check("R9", "rd_status after reset", 36'(rd_status), 36'(0));
        check("R9", "wr_status after reset", 36'(wr_status), 36'(1));
        check("R9", "rd_aempty_n after reset", 36'(rd_aempty_n), 36'(0));
        check("R9", "wr_afull_n after reset", 36'(wr_afull_n), 36'(1));
        check("R9", "rd_data after reset", 36'(rd_data), 36'(0));
    endtask

    task automatic test_order_msb();
        push_word(W1, 1'b0);
        // at most one read edge since the write: still not visible
        check("R10", "status not early after write", 36'(rd_status), 36'(0));
        push_word(W2, 1'b0);
        settle();
        check("R4", "not-empty with data", 36'(rd_status), 36'(1));
        strobe_rd(1'b0, 1'b1);
        check("R3", "W1 upper first", 36'(rd_data), 36'(hi(W1)));
        strobe_rd(1'b0, 1'b1);
        check("R3", "W1 lower second", 36'(rd_data), 36'(lo(W1)));
        strobe_rd(1'b0, 1'b1);
        check("R4", "W2 upper", 36'(rd_data), 36'(hi(W2)));
        strobe_rd(1'b0, 1'b1);
        check("R4", "W2 lower", 36'(rd_data), 36'(lo(W2)));
        settle();
        check("R4", "empty after drain", 36'(rd_status), 36'(0));
    endtask

    task automatic test_empty_read();
        strobe_rd(1'b0, 1'b1);
        check("R4", "read while empty keeps data", 36'(rd_data), 36'(lo(W2)));
        check("R4", "still empty", 36'(rd_status), 36'(0));
    endtask

    task automatic test_select();
        push_word(W1, 1'b1);
        settle();
        check("R1", "deselected write stores nothing", 36'(rd_status), 36'(0));
        push_word(W3, 1'b0);
        settle();
        strobe_rd(1'b1, 1'b1);
        check("R2", "deselected read keeps data", 36'(rd_data), 36'(lo(W2)));
        strobe_rd(1'b0, 1'b0);
        check("R2", "disabled read keeps data", 36'(rd_data), 36'(lo(W2)));
        strobe_rd(1'b0, 1'b1);
        check("R2", "W3 upper after ignored strobes", 36'(rd_data), 36'(hi(W3)));
        strobe_rd(1'b0, 1'b1);
        check("R2", "W3 lower", 36'(rd_data), 36'(lo(W3)));
        settle();
    endtask

    task automatic test_almost_empty();
        push_burst(100, 3);
        settle();
        check("R7", "three words at level three", 36'(rd_aempty_n), 36'(0));
        push_burst(103, 1);
        settle();
        check("R7", "four words above level", 36'(rd_aempty_n), 36'(1));
        strobe_rd(1'b0, 1'b1);
        settle();
        check("R7", "partial word still counted", 36'(rd_aempty_n), 36'(1));
        strobe_rd(1'b0, 1'b1);
        settle();
        check("R7", "three words after full read", 36'(rd_aempty_n), 36'(0));
        for (int i = 0; i < 6; i++) begin
            strobe_rd(1'b0, 1'b1);
        end
        check("R4", "last half of burst", 36'(rd_data), 36'(lo(fill_word(103))));
        settle();
    endtask

    task automatic test_full();
        int bad;
        bad = 0;
        push_burst(0, DEPTH - 5);
        settle();
        check("R8", "five free above level", 36'(wr_afull_n), 36'(1));
        push_burst(DEPTH - 5, 1);
        settle();
        check("R8", "four free at level", 36'(wr_afull_n), 36'(0));
        check("R6", "space before full", 36'(wr_status), 36'(1));
        push_burst(DEPTH - 4, 4);
        settle();
        check("R6", "full after DEPTH words", 36'(wr_status), 36'(0));
        push_word(36'hFFFFFFFFF, 1'b0);
        settle();
        strobe_rd(1'b0, 1'b1);
        check("R6", "first half of oldest", 36'(rd_data), 36'(hi(fill_word(0))));
        settle();
        check("R6", "one half read keeps full", 36'(wr_status), 36'(0));
        strobe_rd(1'b0, 1'b1);
        check("R6", "second half of oldest", 36'(rd_data), 36'(lo(fill_word(0))));
        settle();
        check("R6", "slot freed after both halves", 36'(wr_status), 36'(1));
        for (int i = 1; i < DEPTH; i++) begin
            strobe_rd(1'b0, 1'b1);
            if (rd_data !== hi(fill_word(i))) bad++;
            strobe_rd(1'b0, 1'b1);
            if (rd_data !== lo(fill_word(i))) bad++;
        end
        check("R6", "drain order of full store", 36'(bad), 36'(0));
        settle();
        check("R1", "write into full store dropped", 36'(rd_status), 36'(0));
    endtask

    task automatic test_order_lsb();
        check("R9", "empty after second reset", 36'(rd_status), 36'(0));
        msb_first = 1'b1;
        push_word(W1, 1'b0);
        settle();
        strobe_rd(1'b0, 1'b1);
        check("R3", "lower half first", 36'(rd_data), 36'(lo(W1)));
        strobe_rd(1'b0, 1'b1);
        check("R3", "upper half second", 36'(rd_data), 36'(hi(W1)));
        settle();
    endtask

    task automatic test_fallthru();
        check("R5", "not ready after reset", 36'(rd_status), 36'(0));
        push_word(W1, 1'b0);
        settle();
        check("R5", "ready without strobe", 36'(rd_status), 36'(1));
        check("R5", "first half already present", 36'(rd_data), 36'(hi(W1)));
        repeat (5) @(negedge rclk);
        check("R5", "half held without strobe", 36'(rd_data), 36'(hi(W1)));
        strobe_rd(1'b0, 1'b1);
        check("R5", "strobe shows second half", 36'(rd_data), 36'(lo(W1)));
        check("R5", "still ready on second half", 36'(rd_status), 36'(1));
        strobe_rd(1'b0, 1'b1);
        check("R5", "not ready after last half", 36'(rd_status), 36'(0));
        check("R6", "write side open in fall-through", 36'(wr_status), 36'(1));
    endtask

    initial begin
        do_reset(1'b1, 1'b1);
        test_reset_state();
        test_order_msb();
        test_empty_read();
        test_select();
        test_almost_empty();
        test_full();
        do_reset(1'b0, 1'b1);
        test_order_lsb();
        do_reset(1'b1, 1'b0);
        test_fallthru();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule